// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Collision Flag

A synchronous two-port memory on one clock. Each port can read and write on its own and always works; nothing enables or disables it. A port registers its read result once, so the data for an address sampled on one rising edge is on the port's output until the next edge. Each port has its own parameter that sets what the port shows on a cycle in which it writes: the data it just wrote, the old contents of the location, or its previous output unchanged.

The block also checks, on every edge, whether one port writes the location that the other port presents in the same cycle. That read result is undefined, so the affected port shows a marker pattern (all ones by default) and raises its collision flag for that cycle. The write itself completes. On the next cycle, with no collision, the same address returns the new contents, so a read that collides sees two cycles of latency. When both ports write one address in the same cycle, port A's data is kept and both ports flag a collision.

Top module: `dpram_collide`

## Requirements
- R1: On a cycle with no collision for a port, when that port does not write, its data output in the next cycle is the value the location held before that edge's writes. Its collision flag is 0.
- R2: A write from either port stores its data, and a later read from either port returns that data.
- R3: With the port's mode parameter at 0 (write-first), a writing port without a collision outputs the data it wrote in the next cycle.
- R4: With the mode parameter at 1 (read-first), a writing port without a collision outputs the location's previous contents in the next cycle.
- R5: With the mode parameter at 2 (no-change), a writing port without a collision keeps its data output unchanged, and its collision flag is 0.
- R6: When the other port writes the address a port presents on an edge, that port's collision flag is 1 in the next cycle and its data output equals MARKER (all ones by default). The write is still stored.
- R7: After a collision, the same address read in the following cycle, with no collision, returns the newly written data.
- R8: When both ports write the same address on one edge, port A's data is stored and both ports flag a collision.
- R9: While rst_ni is low, both data outputs and both collision flags are 0. The memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | ADDR_W | Port A address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A read data |
| a_col_o | output | 1 | Port A collision flag, qualifies a_rdata_o |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | ADDR_W | Port B address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B read data |
| b_col_o | output | 1 | Port B collision flag, qualifies b_rdata_o |

## Verification
The bench fills the memory through port A while port B sits on the address being written, which causes a collision on every fill cycle. It then reads everything back, and next fills through port B while port A reads elsewhere. This separates stored data from the marker, and shows whether the flag follows the write or the read. An exhaustive sweep over both write enables and every address pair of an 8-entry memory, run on two copies with different mode settings, covers every write mode on its writing port, same and different addresses, and a write on both ports at one address. Separate sequences with the address held check the latency after a collision and port A's priority.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum int unsigned {
    WM_WRITE_FIRST = 0,
    WM_READ_FIRST  = 1,
    WM_NO_CHANGE   = 2
  } wmode_e;
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] a_q_o,
  output logic [DATA_W-1:0] b_q_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // B first, A last: A wins a same-address double write
  always_ff @(posedge clk_i) begin
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  assign a_q_o = mem_q[a_addr_i];
  assign b_q_o = mem_q[b_addr_i];
endmodule

// File: rtl/dpram_col_det.sv
module dpram_col_det #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic              a_hit_o,
  output logic              b_hit_o
);
  logic same_addr;

  assign same_addr = (a_addr_i == b_addr_i);
  assign a_hit_o   = b_we_i & same_addr;
  assign b_hit_o   = a_we_i & same_addr;
endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
  parameter dpram_pkg::wmode_e MODE   = dpram_pkg::WM_WRITE_FIRST,
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] MARKER = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_q_i,
  input  logic              hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              col_o
);
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] rdata_d;

  if (MODE == dpram_pkg::WM_WRITE_FIRST) begin : g_wf
    assign wr_val = wdata_i;
  end else if (MODE == dpram_pkg::WM_READ_FIRST) begin : g_rf
    assign wr_val = mem_q_i;
  end else begin : g_nc
    assign wr_val = rdata_o;
  end

  always_comb begin
    if (hit_i)     rdata_d = MARKER;
    else if (we_i) rdata_d = wr_val;
    else           rdata_d = mem_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      col_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      col_o   <= hit_i;
    end
  end
endmodule

// File: rtl/dpram_collide.sv
module dpram_collide #(
  parameter int unsigned       ADDR_W = 4,
  parameter int unsigned       DATA_W = 8,
  parameter dpram_pkg::wmode_e MODE_A = dpram_pkg::WM_WRITE_FIRST,
  parameter dpram_pkg::wmode_e MODE_B = dpram_pkg::WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] MARKER = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_col_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_col_o
);
  logic [DATA_W-1:0] a_q, b_q;
  logic              a_hit, b_hit;

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .a_we_i    (a_we_i),
    .a_addr_i  (a_addr_i),
    .a_wdata_i (a_wdata_i),
    .b_we_i    (b_we_i),
    .b_addr_i  (b_addr_i),
    .b_wdata_i (b_wdata_i),
    .a_q_o     (a_q),
    .b_q_o     (b_q)
  );

  dpram_col_det #(.ADDR_W(ADDR_W)) u_col (
    .a_we_i   (a_we_i),
    .a_addr_i (a_addr_i),
    .b_we_i   (b_we_i),
    .b_addr_i (b_addr_i),
    .a_hit_o  (a_hit),
    .b_hit_o  (b_hit)
  );

  dpram_port_out #(.MODE(MODE_A), .DATA_W(DATA_W), .MARKER(MARKER)) u_out_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (a_we_i),
    .wdata_i (a_wdata_i),
    .mem_q_i (a_q),
    .hit_i   (a_hit),
    .rdata_o (a_rdata_o),
    .col_o   (a_col_o)
  );

  dpram_port_out #(.MODE(MODE_B), .DATA_W(DATA_W), .MARKER(MARKER)) u_out_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (b_we_i),
    .wdata_i (b_wdata_i),
    .mem_q_i (b_q),
    .hit_i   (b_hit),
    .rdata_o (b_rdata_o),
    .col_o   (b_col_o)
  );
endmodule

// File: rtl/dpram_collide_chk.sv
module dpram_collide_chk #(
  parameter int unsigned       ADDR_W = 4,
  parameter int unsigned       DATA_W = 8,
  parameter dpram_pkg::wmode_e MODE_A = dpram_pkg::WM_WRITE_FIRST,
  parameter dpram_pkg::wmode_e MODE_B = dpram_pkg::WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] MARKER = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_we_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic [DATA_W-1:0] a_wdata_i,
  input logic [DATA_W-1:0] a_rdata_o,
  input logic              a_col_o,
  input logic              b_we_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic [DATA_W-1:0] b_wdata_i,
  input logic [DATA_W-1:0] b_rdata_o,
  input logic              b_col_o
);
  logic eq;
  logic unused_wdata;

  assign eq           = (a_addr_i == b_addr_i);
  assign unused_wdata = ^{a_wdata_i, b_wdata_i};

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (a_rdata_o == '0 && b_rdata_o == '0 && !a_col_o && !b_col_o); // R9
    end
  end

  AST_COL_A_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_col_o |-> a_rdata_o == MARKER); // R6
  AST_COL_B_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_col_o |-> b_rdata_o == MARKER); // R6
  AST_COL_A_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_we_i && eq) |=> a_col_o); // R6
  AST_COL_B_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && eq) |=> b_col_o); // R6
  AST_COL_A_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_we_i && eq) |=> !a_col_o); // R1
  AST_COL_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_we_i && eq) |=> !b_col_o); // R1
  AST_DUAL_WRITE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && b_we_i && eq) |=> (a_col_o && b_col_o)); // R8

  if (MODE_A == dpram_pkg::WM_WRITE_FIRST) begin : g_a_wf
    AST_A_WRITE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_we_i && !(b_we_i && eq)) |=> a_rdata_o == $past(a_wdata_i)); // R3
  end else if (MODE_A == dpram_pkg::WM_NO_CHANGE) begin : g_a_nc
    AST_A_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_we_i && !(b_we_i && eq)) |=> $stable(a_rdata_o)); // R5
  end

  if (MODE_B == dpram_pkg::WM_WRITE_FIRST) begin : g_b_wf
    AST_B_WRITE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_we_i && !(a_we_i && eq)) |=> b_rdata_o == $past(b_wdata_i)); // R3
  end else if (MODE_B == dpram_pkg::WM_NO_CHANGE) begin : g_b_nc
    AST_B_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_we_i && !(a_we_i && eq)) |=> $stable(b_rdata_o)); // R5
  end
endmodule

bind dpram_collide dpram_collide_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B), .MARKER(MARKER)
) u_chk (.*);

// File: tb/dpram_collide_tb_top.sv
`timescale 1ns/1ps
module dpram_collide_tb_top;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int M1A = 0;
  localparam int M1B = 1;
  localparam int M2A = 2;
  localparam int M2B = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_a = 1'b0, we_b = 1'b0;
  logic [AW-1:0] ad_a = '0, ad_b = '0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic [DW-1:0] rd_a1, rd_b1, rd_a2, rd_b2;
  logic col_a1, col_b1, col_a2, col_b2;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] exp_rd [4];
  logic          exp_col [4];

  always #5 clk = ~clk;

  dpram_collide #(.ADDR_W(AW), .DATA_W(DW),
    .MODE_A(dpram_pkg::WM_WRITE_FIRST), .MODE_B(dpram_pkg::WM_READ_FIRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_we_i(we_a), .a_addr_i(ad_a), .a_wdata_i(wd_a), .a_rdata_o(rd_a1), .a_col_o(col_a1),
    .b_we_i(we_b), .b_addr_i(ad_b), .b_wdata_i(wd_b), .b_rdata_o(rd_b1), .b_col_o(col_b1));

  dpram_collide #(.ADDR_W(AW), .DATA_W(DW),
    .MODE_A(dpram_pkg::WM_NO_CHANGE), .MODE_B(dpram_pkg::WM_WRITE_FIRST)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_we_i(we_a), .a_addr_i(ad_a), .a_wdata_i(wd_a), .a_rdata_o(rd_a2), .a_col_o(col_a2),
    .b_we_i(we_b), .b_addr_i(ad_b), .b_wdata_i(wd_b), .b_rdata_o(rd_b2), .b_col_o(col_b2));

  function automatic logic [DW:0] nxt(int mode, logic we_s, logic we_o, logic eq,
                                      logic [DW-1:0] wd, logic [DW-1:0] oldv, logic [DW-1:0] prev);
    if (we_o && eq) return {1'b1, {DW{1'b1}}};
    if (we_s) begin
      case (mode)
        0:       return {1'b0, wd};
        1:       return {1'b0, oldv};
        default: return {1'b0, prev};
      endcase
    end
    return {1'b0, oldv};
  endfunction

  function automatic string tag_of(int mode, logic we_s, logic we_o, logic eq);
    if (we_o && eq) return (we_s ? "R8" : "R6");
    if (we_s) begin
      case (mode)
        0:       return "R3";
        1:       return "R4";
        default: return "R5";
      endcase
    end
    return "R1";
  endfunction

  task automatic cmp(int idx, string tag, logic [DW-1:0] act, logic actc);
    vectors++;
    if (act !== exp_rd[idx] || actc !== exp_col[idx]) begin
      miscompares++;
      $display("FAIL %s port%0d rd=%h exp %h col=%b exp %b", tag, idx, act, exp_rd[idx], actc, exp_col[idx]);
    end
  endtask

  // Called at a falling edge: drive, model the rising edge, check at the next falling edge
  task automatic step(logic wa, logic [AW-1:0] aa, logic [DW-1:0] da,
                      logic wb, logic [AW-1:0] ab, logic [DW-1:0] db, string force_tag);
    logic eq;
    logic [DW:0] r;
    string t [4];
    we_a = wa; ad_a = aa; wd_a = da;
    we_b = wb; ad_b = ab; wd_b = db;
    eq = (aa == ab);
    @(posedge clk);
    r = nxt(M1A, wa, wb, eq, da, mem_m[aa], exp_rd[0]); {exp_col[0], exp_rd[0]} = r;
    r = nxt(M1B, wb, wa, eq, db, mem_m[ab], exp_rd[1]); {exp_col[1], exp_rd[1]} = r;
    r = nxt(M2A, wa, wb, eq, da, mem_m[aa], exp_rd[2]); {exp_col[2], exp_rd[2]} = r;
    r = nxt(M2B, wb, wa, eq, db, mem_m[ab], exp_rd[3]); {exp_col[3], exp_rd[3]} = r;
    t[0] = tag_of(M1A, wa, wb, eq);
    t[1] = tag_of(M1B, wb, wa, eq);
    t[2] = tag_of(M2A, wa, wb, eq);
    t[3] = tag_of(M2B, wb, wa, eq);
    if (wb) mem_m[ab] = db;
    if (wa) mem_m[aa] = da;
    @(negedge clk);
    if (force_tag != "") for (int i = 0; i < 4; i++) t[i] = force_tag;
    cmp(0, t[0], rd_a1, col_a1);
    cmp(1, t[1], rd_b1, col_b1);
    cmp(2, t[2], rd_a2, col_a2);
    cmp(3, t[3], rd_b2, col_b2);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin exp_rd[i] = '0; exp_col[i] = 1'b0; end
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    // R9: cleared outputs while held in reset
    cmp(0, "R9", rd_a1, col_a1);
    cmp(1, "R9", rd_b1, col_b1);
    cmp(2, "R9", rd_a2, col_a2);
    cmp(3, "R9", rd_b2, col_b2);
    rst_n = 1'b1;
    // Fill via A with B on the same address: collision every cycle
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, AW'(a), DW'(a * 37 + 5), 1'b0, AW'(a), '0, "");
    // R2: read-back on both ports
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, AW'(a), '0, 1'b0, AW'((a + 1) % DEPTH), '0, "R2");
    // Fill via B, A reads elsewhere
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, AW'((a + 3) % DEPTH), '0, 1'b1, AW'(a), DW'(~(a * 13)), "");
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, AW'((a + 5) % DEPTH), '0, 1'b0, AW'(a), '0, "R2");
    // Exhaustive enable/address sweep
    for (int wa = 0; wa < 2; wa++)
      for (int wb = 0; wb < 2; wb++)
        for (int aa = 0; aa < DEPTH; aa++)
          for (int ab = 0; ab < DEPTH; ab++)
            step(wa[0], AW'(aa), DW'(aa * 29 + ab * 3 + wa + 1),
                 wb[0], AW'(ab), DW'(ab * 41 + aa * 7 + wb + 2), "");
    // R7: collide, then hold the address
    step(1'b1, 3'd5, 8'h3C, 1'b0, 3'd5, 8'h00, "R6");
    step(1'b0, 3'd5, 8'h00, 1'b0, 3'd5, 8'h00, "R7");
    step(1'b0, 3'd1, 8'h00, 1'b1, 3'd1, 8'hC3, "R6");
    step(1'b0, 3'd1, 8'h00, 1'b0, 3'd1, 8'h00, "R7");
    // R8: dual write, port A data kept
    step(1'b1, 3'd2, 8'hAA, 1'b1, 3'd2, 8'h55, "R8");
    step(1'b0, 3'd2, 8'h00, 1'b0, 3'd2, 8'h00, "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule